// File: doc/BRIEF.md
# Serial FIFO Level Event Controller

This block holds the transmit and receive byte queues of a serial controller and turns their fill levels into events. The register bus pushes transmit bytes and pops received bytes; the shift engine pops transmit bytes and pushes received bytes. Each queue has its own programmable trigger level. A level condition sets a latched interrupt status bit and, when enabled, drives a DMA request line.

The status bits are cleared by writing ones. Each bit has an enable, and the interrupt line is the OR of every enabled pending bit. Each queue can be flushed from the control word. The flush bit clears itself one cycle later, so software never has to write it back to zero. The queue depth is a parameter, either 64 or 128 bytes.

Top module: `evt_fifo_ctrl`

## Requirements
- R1: While `rst_ni` is low, every output reads zero: fill counts, control word, enable word, status word, interrupt line and both DMA request lines.
- R2: Both queues are first-in first-out, and the head byte is visible at the data output without a pop. A push or pop changes the count one clock edge later. The status word carries the receive count in bits 7:0 and the transmit count in bits 23:16.
- R3: A push into a full queue drops the byte. A receive push while the receive count equals DEPTH also sets the overflow status bit (bit 8) at the next edge. A pop from an empty queue is ignored.
- R4: The receive-ready status bit (bit 0) sets at the edge after a cycle in which the receive count is at least the receive trigger level. The receive trigger level is control bits 7:0.
- R5: The transmit-request status bit (bit 4) sets at the edge after a cycle in which the transmit count is at most the transmit trigger level. The transmit trigger level is control bits 23:16.
- R6: A pulse on `xfer_done_i` sets the transfer-complete status bit (bit 12) at the next edge.
- R7: Writing the status word with `w1c_we_i` clears each bit written as one and leaves bits written as zero unchanged. A set condition in the same cycle wins over the clear. All other status bits read zero.
- R8: The enable word keeps only bits 0, 4, 8 and 12. `irq_o` is high exactly when some status bit is set together with its enable bit.
- R9: `rx_dma_req_o` is high when control bit 8 is set and the current receive count is at least the receive trigger level.
- R10: `tx_dma_req_o` is high when control bit 24 is set and the current transmit count is at most the transmit trigger level.
- R11: Control bit 15 flushes the receive queue and control bit 31 flushes the transmit queue. The flush takes effect at the edge after the write, which also returns the bit to zero. The other control fields keep their value.
- R12: Control word bits other than 0 to 8, 15, 16 to 24 and 31 read zero, and status word bits other than the two count fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write `wdata_i` to the control word |
| ien_we_i | input | 1 | Write `wdata_i` to the enable word |
| w1c_we_i | input | 1 | Clear the status bits that are one in `wdata_i` |
| wdata_i | input | 32 | Register write data |
| tx_push_i | input | 1 | Bus push into the transmit queue |
| tx_data_i | input | 8 | Byte pushed into the transmit queue |
| tx_pop_i | input | 1 | Shift engine pop from the transmit queue |
| tx_data_o | output | 8 | Head byte of the transmit queue |
| rx_push_i | input | 1 | Shift engine push into the receive queue |
| rx_data_i | input | 8 | Byte pushed into the receive queue |
| rx_pop_i | input | 1 | Bus pop from the receive queue |
| rx_data_o | output | 8 | Head byte of the receive queue |
| xfer_done_i | input | 1 | Transfer-complete pulse |
| cfg_o | output | 32 | Control word readback |
| int_en_o | output | 32 | Enable word readback |
| int_sts_o | output | 32 | Latched interrupt status |
| fifo_sts_o | output | 32 | Queue fill counts |
| irq_o | output | 1 | Interrupt request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
A strobe, a register write or a flush shows in the counts, head bytes and readback words one edge after the cycle it is driven. Status bits are one edge behind the counts that cause them, so a level event appears two edges after the push or pop that crosses the level. The DMA requests and `irq_o` follow their registers with no further delay. The bench drives every input just after a rising edge and predicts the state that the next edge must produce. It compares each output one time unit after that edge, so every check lands in the cycle where the result is due and never on the edge itself.

// File: rtl/fifo_evt_pkg.sv
package fifo_evt_pkg;
  // control word field positions (software decodes these)
  localparam int RXLVL_LSB = 0;
  localparam int RXDMA_BIT = 8;
  localparam int RXRST_BIT = 15;
  localparam int TXLVL_LSB = 16;
  localparam int TXDMA_BIT = 24;
  localparam int TXRST_BIT = 31;
  localparam int LVL_W     = 8;
  // interrupt sources, same bit in enable and status words
  localparam int NSRC      = 4;
  localparam int SRC_STEP  = 4;
  localparam int SRC_RXRDY = 0;
  localparam int SRC_TXREQ = 4;
  localparam int SRC_RXOVF = 8;
  localparam int SRC_DONE  = 12;

  typedef struct packed {
    logic             tx_rst;
    logic             tx_dma;
    logic [LVL_W-1:0] tx_lvl;
    logic             rx_rst;
    logic             rx_dma;
    logic [LVL_W-1:0] rx_lvl;
  } cfg_t;
endpackage

// File: rtl/evt_byte_fifo.sv
module evt_byte_fifo #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [7:0]       data_i,
  input  logic             pop_i,
  output logic [7:0]       data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && (cnt_q != '0) && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = CNT_W'(cnt_q);
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import fifo_evt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] set_i,
  input  logic        w1c_we_i,
  input  logic        en_we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] sts_o,
  output logic [31:0] en_o,
  output logic        irq_o
);
  logic [NSRC-1:0] sts_q, en_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int POS = g * SRC_STEP;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q[g] <= 1'b0;
        en_q[g]  <= 1'b0;
      end else begin
        // set has priority over a same-cycle clear
        if (set_i[POS])                  sts_q[g] <= 1'b1;
        else if (w1c_we_i && wdata_i[POS]) sts_q[g] <= 1'b0;
        if (en_we_i) en_q[g] <= wdata_i[POS];
      end
    end
    assign sts_o[POS] = sts_q[g];
    assign en_o[POS]  = en_q[g];
    for (genvar k = 1; k < SRC_STEP; k++) begin : g_pad
      assign sts_o[POS+k] = 1'b0;
      assign en_o[POS+k]  = 1'b0;
    end
  end
  for (genvar p = NSRC * SRC_STEP; p < 32; p++) begin : g_hi
    assign sts_o[p] = 1'b0;
    assign en_o[p]  = 1'b0;
  end

  assign irq_o = |(sts_q & en_q);
endmodule

// File: rtl/evt_fifo_ctrl.sv
module evt_fifo_ctrl
  import fifo_evt_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        ien_we_i,
  input  logic        w1c_we_i,
  input  logic [31:0] wdata_i,
  input  logic        tx_push_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_data_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_pop_i,
  output logic [7:0]  rx_data_o,
  input  logic        xfer_done_i,
  output logic [31:0] cfg_o,
  output logic [31:0] int_en_o,
  output logic [31:0] int_sts_o,
  output logic [31:0] fifo_sts_o,
  output logic        irq_o,
  output logic        rx_dma_req_o,
  output logic        tx_dma_req_o
);
  localparam int CNT_W = LVL_W;

  cfg_t             cfg_q;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             rx_full, tx_full;
  logic             rx_hit, tx_hit;
  logic [31:0]      set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q.rx_lvl <= wdata_i[RXLVL_LSB +: LVL_W];
      cfg_q.rx_dma <= wdata_i[RXDMA_BIT];
      cfg_q.rx_rst <= wdata_i[RXRST_BIT];
      cfg_q.tx_lvl <= wdata_i[TXLVL_LSB +: LVL_W];
      cfg_q.tx_dma <= wdata_i[TXDMA_BIT];
      cfg_q.tx_rst <= wdata_i[TXRST_BIT];
    end else begin
      cfg_q.rx_rst <= 1'b0;
      cfg_q.tx_rst <= 1'b0;
    end
  end

  evt_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni,
    .flush_i(cfg_q.rx_rst), .push_i(rx_push_i), .data_i(rx_data_i),
    .pop_i(rx_pop_i), .data_o(rx_data_o), .count_o(rx_cnt), .full_o(rx_full)
  );

  evt_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni,
    .flush_i(cfg_q.tx_rst), .push_i(tx_push_i), .data_i(tx_data_i),
    .pop_i(tx_pop_i), .data_o(tx_data_o), .count_o(tx_cnt), .full_o(tx_full)
  );

  assign rx_hit = (rx_cnt >= cfg_q.rx_lvl);
  assign tx_hit = (tx_cnt <= cfg_q.tx_lvl);

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_RXRDY] = rx_hit;
    set_vec[SRC_TXREQ] = tx_hit;
    set_vec[SRC_RXOVF] = rx_push_i && rx_full;
    set_vec[SRC_DONE]  = xfer_done_i;
  end

  evt_irq_status u_sts (
    .clk_i, .rst_ni,
    .set_i(set_vec), .w1c_we_i(w1c_we_i), .en_we_i(ien_we_i), .wdata_i(wdata_i),
    .sts_o(int_sts_o), .en_o(int_en_o), .irq_o(irq_o)
  );

  assign rx_dma_req_o = cfg_q.rx_dma && rx_hit;
  assign tx_dma_req_o = cfg_q.tx_dma && tx_hit;

  always_comb begin
    cfg_o = '0;
    cfg_o[RXLVL_LSB +: LVL_W] = cfg_q.rx_lvl;
    cfg_o[RXDMA_BIT]          = cfg_q.rx_dma;
    cfg_o[RXRST_BIT]          = cfg_q.rx_rst;
    cfg_o[TXLVL_LSB +: LVL_W] = cfg_q.tx_lvl;
    cfg_o[TXDMA_BIT]          = cfg_q.tx_dma;
    cfg_o[TXRST_BIT]          = cfg_q.tx_rst;
  end

  assign fifo_sts_o = {8'h00, tx_cnt, 8'h00, rx_cnt};

  logic unused_tx_full;
  assign unused_tx_full = tx_full;
endmodule

// File: rtl/evt_fifo_ctrl_chk.sv
module evt_fifo_ctrl_chk #(
  parameter int DEPTH = 128
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic        ien_we_i,
  input logic        w1c_we_i,
  input logic [31:0] wdata_i,
  input logic        tx_push_i,
  input logic [7:0]  tx_data_i,
  input logic        tx_pop_i,
  input logic [7:0]  tx_data_o,
  input logic        rx_push_i,
  input logic [7:0]  rx_data_i,
  input logic        rx_pop_i,
  input logic [7:0]  rx_data_o,
  input logic        xfer_done_i,
  input logic [31:0] cfg_o,
  input logic [31:0] int_en_o,
  input logic [31:0] int_sts_o,
  input logic [31:0] fifo_sts_o,
  input logic        irq_o,
  input logic        rx_dma_req_o,
  input logic        tx_dma_req_o
);
  AST_RX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fifo_sts_o[7:0]) <= DEPTH); // R2
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_push_i && !rx_pop_i && !cfg_o[15] |=> $stable(fifo_sts_o[7:0])); // R2
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && (32'(fifo_sts_o[7:0]) == DEPTH) |=> int_sts_o[8]); // R3
  AST_RXRDY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_sts_o[7:0] >= cfg_o[7:0] |=> int_sts_o[0]); // R4
  AST_TXREQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_sts_o[23:16] <= cfg_o[23:16] |=> int_sts_o[4]); // R5
  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> int_sts_o[12]); // R6
  AST_DONE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1c_we_i && wdata_i[12] && !xfer_done_i |=> !int_sts_o[12]); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_o == 32'h0) |-> !irq_o); // R8
  AST_RXDMA_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> cfg_o[8]); // R9
  AST_TXDMA_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> cfg_o[24]); // R10
  AST_RST_SELFCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[15] && !(cfg_we_i && wdata_i[15]) |=> !cfg_o[15]); // R11
  AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[15] |=> (fifo_sts_o[7:0] == 8'h00)); // R11
endmodule

bind evt_fifo_ctrl evt_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/evt_fifo_ctrl_tb_top.sv
module evt_fifo_ctrl_tb_top;
  localparam int DEPTH   = 128;
  localparam int CLK_PER = 10;
  localparam logic [31:0] CFG_MASK = 32'h81FF_81FF;
  localparam logic [31:0] SRC_MASK = 32'h0000_1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, ien_we = 0, w1c_we = 0, done = 0;
  logic [31:0] wdata = '0;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0]  tx_din = '0, rx_din = '0;
  logic [7:0]  tx_dout, rx_dout;
  logic [31:0] cfg_rb, ien_rb, sts_rb, fifo_rb;
  logic        irq, rx_req, tx_req;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  logic [7:0]  rq[$], tq[$];
  logic [31:0] m_cfg = '0, m_ien = '0, m_sts = '0;

  always #(CLK_PER/2) clk = ~clk;

  evt_fifo_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .ien_we_i(ien_we), .w1c_we_i(w1c_we), .wdata_i(wdata),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .xfer_done_i(done), .cfg_o(cfg_rb), .int_en_o(ien_rb), .int_sts_o(sts_rb),
    .fifo_sts_o(fifo_rb), .irq_o(irq), .rx_dma_req_o(rx_req), .tx_dma_req_o(tx_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fifo_word();
    return {8'h00, 8'(tq.size()), 8'h00, 8'(rq.size())};
  endfunction

  function automatic logic exp_rx_req();
    return m_cfg[8] && (rq.size() >= int'(m_cfg[7:0]));
  endfunction

  function automatic logic exp_tx_req();
    return m_cfg[24] && (tq.size() <= int'(m_cfg[23:16]));
  endfunction

  task automatic compare_all();
    chk("R2 fill counts", fifo_rb & 32'h00FF_00FF, exp_fifo_word());
    chk("R12 status word reserved", fifo_rb & 32'hFF00_FF00, 32'h0);
    if (rq.size() > 0) chk("R2 rx head", 32'(rx_dout), 32'(rq[0]));
    if (tq.size() > 0) chk("R2 tx head", 32'(tx_dout), 32'(tq[0]));
    chk("R4 rx ready bit", 32'(sts_rb[0]), 32'(m_sts[0]));
    chk("R5 tx request bit", 32'(sts_rb[4]), 32'(m_sts[4]));
    chk("R3 overflow bit", 32'(sts_rb[8]), 32'(m_sts[8]));
    chk("R6 done bit", 32'(sts_rb[12]), 32'(m_sts[12]));
    chk("R7 status word", sts_rb, m_sts);
    chk("R8 enable word", ien_rb, m_ien);
    chk("R8 irq", 32'(irq), 32'(|(m_sts & m_ien)));
    chk("R9 rx dma", 32'(rx_req), 32'(exp_rx_req()));
    chk("R10 tx dma", 32'(tx_req), 32'(exp_tx_req()));
    chk("R11 R12 control readback", cfg_rb, m_cfg);
  endtask

  // predict the next edge from the current inputs, then compare after it
  task automatic cycle();
    int rc = rq.size();
    int tc = tq.size();
    logic [31:0] set = '0;
    set[0]  = (rc >= int'(m_cfg[7:0]));
    set[4]  = (tc <= int'(m_cfg[23:16]));
    set[8]  = rx_push && (rc == DEPTH);
    set[12] = done;
    if (m_cfg[15]) rq.delete();
    else begin
      if (rx_pop && rc > 0) void'(rq.pop_front());
      if (rx_push && rc < DEPTH) rq.push_back(rx_din);
    end
    if (m_cfg[31]) tq.delete();
    else begin
      if (tx_pop && tc > 0) void'(tq.pop_front());
      if (tx_push && tc < DEPTH) tq.push_back(tx_din);
    end
    m_sts = ((m_sts & ~(w1c_we ? wdata : 32'h0)) | set) & SRC_MASK;
    if (cfg_we) m_cfg = wdata & CFG_MASK;
    else begin
      m_cfg[15] = 1'b0;
      m_cfg[31] = 1'b0;
    end
    if (ien_we) m_ien = wdata & SRC_MASK;
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle();
    cfg_we = 0; ien_we = 0; w1c_we = 0; done = 0;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset fifo", fifo_rb, 32'h0);
    chk("R1 reset status", sts_rb, 32'h0);
    chk("R1 reset enable", ien_rb, 32'h0);
    chk("R1 reset control", cfg_rb, 32'h0);
    chk("R1 reset outputs", {29'h0, irq, rx_req, tx_req}, 32'h0);
    rst_n = 1'b1;

    // levels, DMA enables, reserved bits set in the write (R12)
    idle(); cfg_we = 1; wdata = 32'h0102_0104 | 32'h0E00_7000; cycle();
    idle(); ien_we = 1; wdata = 32'hFFFF_FFFF; cycle();
    idle(); w1c_we = 1; wdata = 32'hFFFF_FFFF; cycle();
    for (int i = 0; i < 6; i++) begin
      idle(); tx_push = 1; tx_din = 8'hA0 + 8'(i); rx_push = 1; rx_din = 8'h50 + 8'(i); cycle();
    end
    idle(); cycle(); cycle();
    // R7 clear with all ones; level conditions are re-set at the same edge
    idle(); w1c_we = 1; wdata = 32'hFFFF_FFFF; cycle();
    idle(); cycle();
    // R3 pop on empty tx after draining
    for (int i = 0; i < 8; i++) begin
      idle(); tx_pop = 1; cycle();
    end
    // R3 fill rx past full
    for (int i = 0; i < DEPTH + 3; i++) begin
      idle(); rx_push = 1; rx_din = 8'(i * 7 + 3); cycle();
    end
    idle(); cycle();
    chk("R3 overflow latched after fill", 32'(sts_rb[8]), 32'h1);
    // R11 rx flush keeps levels
    idle(); cfg_we = 1; wdata = 32'h0102_8104; cycle();
    idle(); cycle();
    chk("R11 flush emptied rx", 32'(fifo_rb[7:0]), 32'h0);
    chk("R11 flush bit cleared", 32'(cfg_rb[15]), 32'h0);
    // R6 done pulse, then clear it
    idle(); done = 1; cycle();
    idle(); w1c_we = 1; wdata = 32'h0000_1000; cycle();
    idle(); cycle();

    // random phases with biased push/pop rates
    for (int ph = 0; ph < 8; ph++) begin
      int push_w = (ph % 2 == 0) ? 7 : 3;
      for (int c = 0; c < 400; c++) begin
        idle();
        rx_push = ($urandom_range(0, 9) < push_w);
        rx_pop  = ($urandom_range(0, 9) >= push_w);
        tx_push = ($urandom_range(0, 9) < push_w);
        tx_pop  = ($urandom_range(0, 9) >= push_w);
        rx_din  = 8'($urandom);
        tx_din  = 8'($urandom);
        done    = ($urandom_range(0, 29) == 0);
        wdata   = $urandom;
        case ($urandom_range(0, 39))
          0: begin
            cfg_we = 1;
            wdata = ($urandom & 32'h8100_8100)
                  | (32'($urandom_range(0, DEPTH)) << 16)
                  | 32'($urandom_range(0, DEPTH));
          end
          1: ien_we = 1;
          2, 3, 4, 5, 6: w1c_we = 1;
          default: ;
        endcase
        cycle();
      end
    end
    idle(); cycle();
    finish_run();
  end
endmodule